// File: doc/BRIEF.md
# Serial Frame Transmitter with Empty and Complete Flags

This block is the sending half of a byte-oriented asynchronous serial port. Software writes a character to the data register. When the sender is enabled and idle, the block starts a frame at once. A frame is a low start bit, then the data bits least significant first, an optional extra data bit, and a high stop bit. The frame advances one bit on each pulse of a bit-rate tick that an external rate generator supplies.

Two status flags report the sender's state. The holding-empty flag shows that a new character can be written. The complete flag shows that no frame is on the line. Each flag has its own interrupt enable, and the two enabled terms are ORed onto a single interrupt request. A status write strobe exists, but it never changes either flag.

Top module: `sertx_top`

## Requirements
- R1: Out of reset, both the holding-empty flag and the complete flag read 1, the line reads 1, and the interrupt request is 0 while both interrupt enables are 0.
- R2: A data write made while the holding-empty flag is 0 is refused. Nothing is stored, so once the current frame ends no further frame is sent and the flags stay at 1.
- R3: A data write accepted while the sender is enabled and idle starts a frame at that same clock edge. From the next cycle both flags read 0 and the line drives the start bit (0).
- R4: A data write accepted while the enable is 0 is held as pending and leaves both flags at 1. A later accepted write replaces the pending character. The pending character is sent as soon as the enable is 1.
- R5: With the length-select input at 0, a frame is exactly 10 bit ticks long: one 0, then data bits 0 to 7, then one 1.
- R6: With the length-select input at 1, a frame is 11 bit ticks long. The extra data bit follows data bit 7 and takes the value of the ninth-bit input at the clock edge where the frame loads. Later changes to that input have no effect on the frame.
- R7: On the tick that ends the last bit of a frame, both flags return to 1 and the line returns to 1. If a character is pending and the sender is enabled, it loads at that same edge instead.
- R8: The status write strobe never changes either flag, whether or not a frame is in progress.
- R9: The line is 1 whenever no frame is in progress.
- R10: The interrupt request equals (empty-interrupt enable AND holding-empty flag) OR (complete-interrupt enable AND complete flag).
- R11: If the enable is dropped in the middle of a frame, that frame still completes in full, and the line then stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time from the rate generator |
| tx_en | input | 1 | Sender enable |
| ie_empty | input | 1 | Interrupt enable for the holding-empty flag |
| ie_done | input | 1 | Interrupt enable for the complete flag |
| long_char | input | 1 | Length select: 1 adds the extra data bit |
| ninth_bit | input | 1 | Value of the extra data bit |
| wr_data | input | 1 | Write strobe for the data register |
| wr_stat | input | 1 | Write strobe for the status register (no effect) |
| wr_byte | input | DATA_W | Write data |
| stat_empty | output | 1 | Holding-empty flag |
| stat_done | output | 1 | Complete flag |
| txd | output | 1 | Serial line |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and the combinational interrupt output (IRQ_REG = 0), and drives a bit tick every four clocks. With an 8-bit character, the bench can send every possible byte in both length modes, which is 512 frames in total. It compares every bit of each frame against a pattern computed arithmetically, and it toggles the ninth-bit input throughout each frame to show that only its value at load time is sent. Directed sequences cover the remaining cases: refused writes, pending writes made while disabled, a pending character replaced by a later write, status writes during and outside a frame, an enable dropped in the middle of a frame, and all four interrupt-enable combinations.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef struct packed {
      logic empty;
      logic done;
   } sertx_flags_t;

   // bits on the line for one character: start + data + optional extra + stop
   function automatic int unsigned frame_len(input int unsigned dw, input logic ext);
      return dw + 2 + (ext ? 1 : 0);
   endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              can_accept,
   input  logic              take,
   output logic              avail,
   output logic [DATA_W-1:0] out_byte
);
   logic              pend_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   assign accept   = wr_en & can_accept;
   assign avail    = pend_q | accept;
   assign out_byte = accept ? wr_byte : data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (accept) data_q <= wr_byte;
         if (take)        pend_q <= 1'b0;
         else if (accept) pend_q <= 1'b1;
      end
   end

   AST_REFUSED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !can_accept && !pend_q) |=> !pend_q); // R2

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_byte,
   input  logic              load_ext,
   input  logic              load_ninth,
   input  logic              tick,
   output logic              busy,
   output logic              finish,
   output logic              txd
);
   localparam int unsigned SH_W  = DATA_W + 3;
   localparam int unsigned CNT_W = $clog2(SH_W + 1);

   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_idx;
   logic             ext_q;
   logic             busy_q;
   logic [SH_W-1:0]  frame_w;

   assign last_idx = CNT_W'(frame_len(DATA_W, ext_q) - 1);
   assign frame_w  = {1'b1, (load_ext ? load_ninth : 1'b1), load_byte, 1'b0};
   assign finish   = busy_q & tick & (cnt_q == last_idx);
   assign busy     = busy_q;
   assign txd      = busy_q ? sh_q[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         ext_q  <= 1'b0;
         busy_q <= 1'b0;
      end else if (load) begin
         sh_q   <= frame_w;
         cnt_q  <= '0;
         ext_q  <= load_ext;
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         sh_q  <= {1'b1, sh_q[SH_W-1:1]};
         cnt_q <= cnt_q + 1'b1;
         if (finish) busy_q <= 1'b0;
      end
   end

   AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= last_idx)); // R5

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags
   import sertx_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         finish,
   input  logic         stat_wr,
   output sertx_flags_t flags
);
   sertx_flags_t fl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_q <= '{empty: 1'b1, done: 1'b1};
      end else if (load) begin
         fl_q <= '{empty: 1'b0, done: 1'b0};
      end else if (finish) begin
         fl_q <= '{empty: 1'b1, done: 1'b1};
      end
   end

   assign flags = fl_q;

   AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !load && !finish) |=> $stable(fl_q)); // R8

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
   import sertx_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  sertx_flags_t flags,
   input  logic         ie_empty,
   input  logic         ie_done,
   output logic         irq
);
   logic irq_d;

   assign irq_d = (ie_empty & flags.empty) | (ie_done & flags.done);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = irq_d;
   end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_en,
   input  logic              ie_empty,
   input  logic              ie_done,
   input  logic              long_char,
   input  logic              ninth_bit,
   input  logic              wr_data,
   input  logic              wr_stat,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              stat_empty,
   output logic              stat_done,
   output logic              txd,
   output logic              irq
);
   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("sertx_top: DATA_W must lie in 5..16");
   end

   sertx_flags_t      flags;
   logic              avail;
   logic [DATA_W-1:0] hold_byte;
   logic              busy;
   logic              frame_fin;
   logic              load;

   assign load = tx_en & avail & (~busy | frame_fin);

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_data),
      .wr_byte    (wr_byte),
      .can_accept (flags.empty),
      .take       (load),
      .avail      (avail),
      .out_byte   (hold_byte)
   );

   sertx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_byte  (hold_byte),
      .load_ext   (long_char),
      .load_ninth (ninth_bit),
      .tick       (bit_tick),
      .busy       (busy),
      .finish     (frame_fin),
      .txd        (txd)
   );

   sertx_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .finish  (frame_fin),
      .stat_wr (wr_stat),
      .flags   (flags)
   );

   sertx_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flags),
      .ie_empty (ie_empty),
      .ie_done  (ie_done),
      .irq      (irq)
   );

   assign stat_empty = flags.empty;
   assign stat_done  = flags.done;

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      stat_done |-> txd); // R9

   AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_done) |-> !txd); // R3

   AST_TAIL_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !stat_done && !frame_fin) |=> !stat_done); // R11

endmodule

// File: tb/sertx_top_bench.sv
module sertx_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int DW         = 8;
   localparam int LIMIT      = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, ie_empty = 1'b0, ie_done = 1'b0;
   logic long_char = 1'b0, ninth_bit = 1'b0;
   logic wr_data = 1'b0, wr_stat = 1'b0;
   logic [DW-1:0] wr_byte = '0;
   logic stat_empty, stat_done, txd, irq;
   logic bit_tick;
   logic [1:0] div_q;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= (div_q == 2'(DIV-1)) ? '0 : div_q + 2'd1;
   end
   assign bit_tick = (div_q == 2'(DIV-1));

   sertx_top #(.DATA_W(DW), .IRQ_REG(1'b0)) u_sertx_top (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
      .ie_empty(ie_empty), .ie_done(ie_done), .long_char(long_char),
      .ninth_bit(ninth_bit), .wr_data(wr_data), .wr_stat(wr_stat),
      .wr_byte(wr_byte), .stat_empty(stat_empty), .stat_done(stat_done),
      .txd(txd), .irq(irq)
   );

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT) begin
         miscompares++;
         $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, LIMIT);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] exp_frame(input logic [DW-1:0] b, input logic ext, input logic n);
      logic [11:0] f = '1;
      f[0] = 1'b0;
      f[DW:1] = b;
      if (ext) f[DW+1] = n;
      return f;
   endfunction

   // Call right after the posedge where a frame loads. Collects line bits at tick
   // cycles until the complete flag returns; optional mid-frame disturbances.
   task automatic collect(input logic [11:0] exp, input int len, input string req,
                          input int refuse_at, input int stat_at, input int drop_at);
      logic [11:0] got = '1;
      int n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         wr_data = 1'b0;
         wr_stat = 1'b0;
         ninth_bit = ~ninth_bit;
         if (i == 0) begin
            check(!stat_empty && !stat_done, "R3 flags clear at frame start",
                  {stat_empty, stat_done}, 0);
            check(irq == 1'b0, "R10 irq while both flags clear", irq, 0);
         end
         if (stat_done) break;
         if (i == refuse_at) begin wr_data = 1'b1; wr_byte = ~wr_byte; end
         if (i == stat_at)   wr_stat = 1'b1;
         if (i == drop_at)   tx_en = 1'b0;
         if (bit_tick) begin
            if (n < 12) got[n] = txd;
            n++;
         end
      end
      wr_data = 1'b0;
      wr_stat = 1'b0;
      check(n == len, {req, " frame length"}, n, len);
      for (int k = 0; k < 12; k++)
         if (k >= len) begin got[k] = 1'b1; end
      check(got == (exp | ~((12'd1 << len) - 12'd1)), {req, " frame bits"}, got, exp);
      check(stat_empty && stat_done && txd, "R7 flags and line restored",
            {stat_empty, stat_done, txd}, 3'b111);
   endtask

   task automatic send(input logic [DW-1:0] b, input logic ext, input logic n,
                       input string req, input int refuse_at, input int stat_at, input int drop_at);
      @(negedge clk);
      wr_data = 1'b1;
      wr_byte = b;
      long_char = ext;
      ninth_bit = n;
      @(posedge clk);
      collect(exp_frame(b, ext, n), ext ? 11 : 10, req, refuse_at, stat_at, drop_at);
   endtask

   task automatic idle_watch(input int cycles, input string req);
      int bad = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (!txd || !stat_done || !stat_empty) bad++;
      end
      check(bad == 0, req, bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(stat_empty == 1'b1, "R1 empty after reset", stat_empty, 1);
      check(stat_done == 1'b1, "R1 complete after reset", stat_done, 1);
      check(txd == 1'b1, "R1 line after reset", txd, 1);
      check(irq == 1'b0, "R1 irq after reset", irq, 0);

      // R10 all enable combinations while idle
      for (int c = 0; c < 4; c++) begin
         ie_empty = c[0];
         ie_done = c[1];
         @(negedge clk);
         check(irq == (c[0] | c[1]), "R10 irq idle", irq, int'(c[0] | c[1]));
      end

      // R8 status write while idle
      wr_stat = 1'b1;
      @(negedge clk);
      wr_stat = 1'b0;
      @(negedge clk);
      check(stat_empty && stat_done, "R8 status write idle", {stat_empty, stat_done}, 3);

      tx_en = 1'b1;
      // R5 every byte, short frames
      for (int b = 0; b < 256; b++)
         send(8'(b), 1'b0, 1'b0, "R5", -1, -1, -1);
      // R6 every byte, long frames, ninth input toggling after load
      for (int b = 0; b < 256; b++)
         send(8'(b), 1'b1, ^8'(b), "R6", -1, -1, -1);

      // R2 refused write mid-frame, R8 status write mid-frame
      send(8'hA5, 1'b0, 1'b0, "R2", 9, 17, -1);
      idle_watch(60, "R2 refused write sends nothing");

      // R11 drop enable mid-frame
      send(8'h3C, 1'b1, 1'b1, "R11", -1, -1, 14);
      idle_watch(40, "R11 line idle after tail");

      // R4 pending while disabled, later write replaces
      @(negedge clk);
      wr_data = 1'b1; wr_byte = 8'h11; long_char = 1'b0;
      @(negedge clk);
      wr_byte = 8'hC6;
      @(negedge clk);
      wr_data = 1'b0;
      idle_watch(30, "R4 disabled pending holds flags");
      tx_en = 1'b1;
      @(posedge clk);
      collect(exp_frame(8'hC6, 1'b0, 1'b0), 10, "R4", -1, -1, -1);
      idle_watch(30, "R4 single pending frame");

      finish_run();
   end
endmodule